// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block decides whether a received frame should be kept, judging only its 48-bit destination address. A start pulse captures the address. The block then runs a reflected CRC-32 over the six address bytes, one nibble per clock. Each byte therefore takes two clocks. The low six bits of the CRC select one bit of a 64-bit hash table. The frame is accepted when that bit is set, or when the address equals the station address. Two mode inputs widen acceptance. One accepts every group-addressed frame, and the other accepts everything.

The hash table is written as eight byte-wide registers through a simple write strobe. The highest table bit is held at one in hardware, so the all-ones broadcast address always passes. The block does not parse frames and does not check the frame CRC. Its caller hands it a destination address and waits for the done strobe. The accept flag and hash index keep their values until the next completion.

The controller has three states. ST_IDLE waits for a start. ST_RUN performs twelve nibble steps. ST_LOOK performs the table lookup and publishes the result. The transitions are:
- ST_IDLE to ST_RUN on start.
- ST_RUN to ST_RUN while steps remain.
- ST_RUN to ST_LOOK after the twelfth step.
- ST_LOOK to ST_IDLE unconditionally.

Top module: `mcast_hash_filter`

## Requirements
- R1: After reset, `done`, `busy`, `accept` and `hash_idx` are all 0. After reset, every table byte is 0 except for the forced bit described in R5.
- R2: `start` is sampled at a clock edge while `busy` is low. Count that edge as edge 0:
  - `busy` is high after edges 0 through 12.
  - `done` is high for exactly one cycle, after edge 13.
  - `busy` is low while `done` is high.
- R3: `hash_idx` is bits [5:0] of a reflected CRC-32 of the address, with no final inversion. The CRC uses polynomial 0xEDB88320 and starts from 0xFFFFFFFF. The bytes are taken first byte first, where the first byte is `dest_addr[47:40]` and the last is `dest_addr[7:0]`. Each byte is XORed into the CRC's low byte and then processed as two 4-bit steps. `hash_idx` holds its value between completions.
- R4: For an index n, the table bit is bit n mod 8 of table byte n/8. When that bit is 1, `accept` is 1 at `done`. When it is 0 and no other rule applies, `accept` is 0.
- R5: Table byte 7 bit 7 (index 63) always reads as 1, whatever value is written to byte 7. As a result, the broadcast address is accepted.
- R6: `accept` is 1 at `done` when `dest_addr` equals `station_addr`. Both values are sampled at start.
- R7: When `pass_all_grp` is 1, every address whose group bit `dest_addr[40]` is 1 is accepted. The table is not consulted for this rule. Addresses whose group bit is 0 are unaffected by `pass_all_grp`.
- R8: When `promisc` is 1, `accept` is 1 at every `done`.
- R9: A `start` that arrives while `busy` is high is ignored. The current result, its timing and its address are unchanged, and no extra `done` follows.
- R10: A cycle with `cfg_wr_en` high replaces table byte `cfg_wr_idx` with `cfg_wr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Table byte write strobe |
| cfg_wr_idx | input | 3 | Table byte number |
| cfg_wr_data | input | 8 | Table byte value |
| station_addr | input | 48 | Own station address for exact match |
| promisc | input | 1 | Accept every address |
| pass_all_grp | input | 1 | Accept every group address |
| start | input | 1 | Capture `dest_addr` and begin |
| dest_addr | input | 48 | Destination address, first wire byte in [47:40] |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | One-cycle result strobe |
| accept | output | 1 | Filter decision, held between results |
| hash_idx | output | 6 | Computed table index, held between results |

## Verification
The bench runs several address patterns, and each one isolates a different accept path:
- A reserved group address, compared against a bit-serial software CRC. This tells a correct nibble table and byte order apart from a wrong one.
- The same address again after its table bit has been written. This separates table decoding from CRC errors.
- A broadcast address with byte 7 cleared, which exercises the forced bit.
- A unicast address equal to the station address, which exercises the exact-match path.
- A group address and a unicast address under the pass-all mode, which shows that the group bit is what is decoded.
- Promiscuous mode, which forces acceptance.

A second start issued mid-run shows whether the block restarts or keeps its first result.

// File: rtl/mhf_pkg.sv
package mhf_pkg;

    localparam int          CRC_W    = 32;
    localparam logic [31:0] CRC_POLY = 32'hEDB88320;
    localparam logic [31:0] CRC_INIT = 32'hFFFFFFFF;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_LOOK = 2'd2
    } fsm_t;

    // Contribution of one low nibble after four reflected shift steps.
    function automatic logic [31:0] nib_entry(input logic [3:0] nib);
        logic [31:0] c;
        c = {28'd0, nib};
        for (int i = 0; i < 4; i++) begin
            if (c[0]) c = (c >> 1) ^ CRC_POLY;
            else      c = c >> 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/mhf_crc_nibble.sv
module mhf_crc_nibble
    import mhf_pkg::*;
(
    input  logic [CRC_W-1:0] crc_in,
    output logic [CRC_W-1:0] crc_out
);
    localparam int ENTRIES = 16;

    logic [CRC_W-1:0] lut [ENTRIES];

    // The table is built once from the polynomial, one constant per nibble value.
    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_lut
            assign lut[g] = nib_entry(4'(g));
        end
    endgenerate

    assign crc_out = (crc_in >> 4) ^ lut[crc_in[3:0]];

endmodule

// File: rtl/mhf_hash_table.sv
module mhf_hash_table #(
    parameter int TBL_BYTES = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [$clog2(TBL_BYTES)-1:0]   wr_idx,
    input  logic [7:0]                     wr_data,
    input  logic [$clog2(TBL_BYTES*8)-1:0] rd_idx,
    output logic                           rd_bit
);
    localparam int BITS  = TBL_BYTES * 8;
    localparam int BIDX_W = $clog2(TBL_BYTES);

    logic [7:0]      bytes_q [TBL_BYTES];
    logic [BITS-1:0] flat;

    genvar b;
    generate
        for (b = 0; b < TBL_BYTES; b++) begin : g_byte
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    bytes_q[b] <= 8'h00;
                end else if (wr_en && wr_idx == BIDX_W'(b)) begin
                    bytes_q[b] <= wr_data;
                end
            end
            // The top bit of the last byte is held high so broadcast always hits.
            if (b == TBL_BYTES - 1) begin : g_top
                assign flat[b*8 +: 8] = bytes_q[b] | 8'h80;
            end else begin : g_plain
                assign flat[b*8 +: 8] = bytes_q[b];
            end
        end
    endgenerate

    assign rd_bit = flat[rd_idx];

endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter
    import mhf_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int TBL_BYTES  = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_wr_en,
    input  logic [$clog2(TBL_BYTES)-1:0]   cfg_wr_idx,
    input  logic [7:0]                     cfg_wr_data,
    input  logic [ADDR_BYTES*8-1:0]        station_addr,
    input  logic                           promisc,
    input  logic                           pass_all_grp,
    input  logic                           start,
    input  logic [ADDR_BYTES*8-1:0]        dest_addr,
    output logic                           busy,
    output logic                           done,
    output logic                           accept,
    output logic [$clog2(TBL_BYTES*8)-1:0] hash_idx
);
    localparam int ADDR_W    = ADDR_BYTES * 8;
    localparam int NIB_STEPS = ADDR_BYTES * 2;
    localparam int STEP_W    = $clog2(NIB_STEPS + 1);
    localparam int IDX_W     = $clog2(TBL_BYTES * 8);
    localparam int GRP_BIT   = ADDR_W - 8;

    fsm_t             state, state_nx;
    logic [ADDR_W-1:0] addr_sh;
    logic [CRC_W-1:0]  crc_q, crc_mix, crc_step;
    logic [STEP_W-1:0] step_q;
    logic              grp_q, match_q;
    logic              tbl_hit;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_RUN;
            ST_RUN:  if (step_q == STEP_W'(NIB_STEPS - 1)) state_nx = ST_LOOK;
            ST_LOOK: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // On even steps the next address byte is folded into the CRC low byte.
    always_comb begin
        crc_mix = crc_q;
        if (!step_q[0]) crc_mix[7:0] = crc_q[7:0] ^ addr_sh[ADDR_W-1 -: 8];
    end

    mhf_crc_nibble u_nib (
        .crc_in  (crc_mix),
        .crc_out (crc_step)
    );

    mhf_hash_table #(.TBL_BYTES(TBL_BYTES)) u_tbl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_idx  (cfg_wr_idx),
        .wr_data (cfg_wr_data),
        .rd_idx  (crc_q[IDX_W-1:0]),
        .rd_bit  (tbl_hit)
    );

    // Datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_sh <= '0;
            crc_q   <= CRC_INIT;
            step_q  <= '0;
            grp_q   <= 1'b0;
            match_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        addr_sh <= dest_addr;
                        crc_q   <= CRC_INIT;
                        step_q  <= '0;
                        grp_q   <= dest_addr[GRP_BIT];
                        match_q <= (dest_addr == station_addr);
                    end
                end
                ST_RUN: begin
                    crc_q  <= crc_step;
                    step_q <= step_q + STEP_W'(1);
                    if (step_q[0]) addr_sh <= addr_sh << 8;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done     <= 1'b0;
            accept   <= 1'b0;
            hash_idx <= '0;
        end else begin
            done <= 1'b0;
            if (state == ST_LOOK) begin
                done     <= 1'b1;
                hash_idx <= crc_q[IDX_W-1:0];
                accept   <= promisc | (pass_all_grp & grp_q) | match_q | tbl_hit;
            end
        end
    end

    assign busy = (state != ST_IDLE);

endmodule

// File: rtl/mcast_hash_filter_chk.sv
module mcast_hash_filter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic       accept,
    input logic       promisc,
    input logic [5:0] hash_idx
);
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R2
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R2
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R2
    AST_PROMISC_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(promisc)) |-> accept); // R8
    AST_ACCEPT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(accept)); // R4
    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(hash_idx)); // R3
endmodule

bind mcast_hash_filter mcast_hash_filter_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .accept   (accept),
    .promisc  (promisc),
    .hash_idx (hash_idx)
);

// File: tb/mcast_hash_filter_test.sv
module mcast_hash_filter_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr_en;
    logic [2:0]  cfg_wr_idx;
    logic [7:0]  cfg_wr_data;
    logic [47:0] station_addr;
    logic        promisc, pass_all_grp, start;
    logic [47:0] dest_addr;
    logic        busy, done, accept;
    logic [5:0]  hash_idx;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;
    logic [7:0] tbl [8];

    always #4 clk = ~clk; // 125 MHz

    mcast_hash_filter uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_idx(cfg_wr_idx),
        .cfg_wr_data(cfg_wr_data), .station_addr(station_addr), .promisc(promisc),
        .pass_all_grp(pass_all_grp), .start(start), .dest_addr(dest_addr),
        .busy(busy), .done(done), .accept(accept), .hash_idx(hash_idx)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Bit-serial reflected CRC, first byte first, no final inversion.
    function automatic logic [31:0] model_crc(input logic [47:0] a);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int k = 0; k < 6; k++) begin
            logic [7:0] b = a[47 - 8*k -: 8];
            for (int i = 0; i < 8; i++) begin
                if (c[0] ^ b[i]) c = (c >> 1) ^ 32'hEDB88320;
                else             c = c >> 1;
            end
        end
        return c;
    endfunction

    function automatic bit model_accept(input logic [47:0] a);
        int n = int'(model_crc(a) & 32'h3F);
        bit hit = tbl[n / 8][n % 8] || (n == 63);
        return promisc || (pass_all_grp && a[40]) || (a == station_addr) || hit;
    endfunction

    task automatic wr_tbl(input int idx, input logic [7:0] val);
        cfg_wr_en = 1; cfg_wr_idx = 3'(idx); cfg_wr_data = val;
        @(negedge clk);
        cfg_wr_en = 0;
        tbl[idx] = val;
    endtask

    // Compare busy/done every cycle and the result at the done cycle.
    task automatic run_addr(input logic [47:0] a, input string tag,
                            input bit overlap, input logic [47:0] b);
        bit          exp_acc = model_accept(a);
        logic [5:0]  exp_idx = 6'(model_crc(a));
        dest_addr = a; start = 1;
        @(negedge clk);
        start = 0;
        for (int n = 0; n < 16; n++) begin
            chk({tag, " R2 busy"}, 64'(busy), 64'(n <= 12));
            chk({tag, " R2 done"}, 64'(done), 64'(n == 13));
            if (n == 13) begin
                chk({tag, " R3 idx"}, 64'(hash_idx), 64'(exp_idx));
                chk({tag, " accept"}, 64'(accept), 64'(exp_acc));
            end
            if (overlap && n == 4) begin start = 1; dest_addr = b; end
            if (n == 5) start = 0;
            @(negedge clk);
        end
    endtask

    initial begin
        rst_n = 0; cfg_wr_en = 0; cfg_wr_idx = 0; cfg_wr_data = 0;
        station_addr = 48'h02_AA_BB_CC_DD_EE; promisc = 0; pass_all_grp = 0;
        start = 0; dest_addr = 0;
        for (int i = 0; i < 8; i++) tbl[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk("R1 done", 64'(done), 0);
        chk("R1 busy", 64'(busy), 0);
        chk("R1 accept", 64'(accept), 0);
        chk("R1 idx", 64'(hash_idx), 0);
        rst_n = 1;
        @(negedge clk);

        // R3: reserved group address against the bit-serial model
        run_addr(48'h01_80_C2_00_00_00, "R3 reserved", 0, 0);
        // R4/R10: set the selected bit, then accept
        begin
            int n = int'(model_crc(48'h01_80_C2_00_00_00) & 32'h3F);
            wr_tbl(n / 8, 8'(1 << (n % 8)));
            run_addr(48'h01_80_C2_00_00_00, "R4 R10 hit", 0, 0);
            wr_tbl(n / 8, 8'h00);
            run_addr(48'h01_80_C2_00_00_00, "R4 cleared", 0, 0);
        end
        run_addr(48'h02_11_22_33_44_55, "R4 unicast reject", 0, 0);
        // R5: broadcast survives a cleared top byte
        wr_tbl(7, 8'h00);
        run_addr(48'hFF_FF_FF_FF_FF_FF, "R5 broadcast", 0, 0);
        // R6: exact station match
        run_addr(48'h02_AA_BB_CC_DD_EE, "R6 station", 0, 0);
        // R7: pass-all-group
        pass_all_grp = 1;
        run_addr(48'h33_33_00_00_00_01, "R7 group", 0, 0);
        run_addr(48'h02_11_22_33_44_56, "R7 unicast", 0, 0);
        pass_all_grp = 0;
        // R8: promiscuous
        promisc = 1;
        run_addr(48'h02_11_22_33_44_57, "R8 promisc", 0, 0);
        promisc = 0;
        // R9: second start mid-run ignored, original address result kept
        run_addr(48'h02_11_22_33_44_58, "R9 overlap", 1, 48'h02_AA_BB_CC_DD_EE);
        chk("R9 still idle", 64'(busy), 0);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog R2 actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule